// File: doc/BRIEF.md
# Edge-Triggered Serial Interrupt Channels

This block raises interrupt requests for one full-duplex serial port. It serves four channels: receive-normal, receive-error, transmit-normal and transmit-error. Each channel watches a group of status flags that are ORed into one level. A request is latched only when that level goes from low to high while the channel is enabled. A flag that rose while its channel was disabled is not remembered. Enabling the channel later does not raise a request, and only a fresh low-to-high change can do so.

Software or an interrupt controller clears a latched request with a per-channel acknowledge strobe. Each request reaches the shared interrupt line through its own mask bit. When the interrupt channels are left disabled, a data mover can follow the combined receive-normal and transmit-normal flag levels instead. These levels are brought out as two ready outputs.

Top module: `serial_irq_edge_ctrl`

## Requirements
- R1: Channel index k in `enable_i`, `mask_i`, `ack_i` and `pending_o` is 0 = receive-normal, 1 = receive-error, 2 = transmit-normal, 3 = transmit-error. Channel k owns flag bits `flag_i[k*FLAGS_PER_CH +: FLAGS_PER_CH]`. A low-to-high change of the OR of those bits while `enable_i[k]` is 1 sets `pending_o[k]` from the next rising clock edge.
- R2: A flag group that stays high produces no new request after the first.
- R3: A rising change that occurs while the channel is disabled is lost. Enabling the channel afterwards, with the flags still high, leaves `pending_o[k]` at 0.
- R4: A set pending bit stays set until `ack_i[k]` is 1 at a clock edge. It reads 0 after that edge.
- R5: When `ack_i[k]` and a qualifying rising change occur at the same clock edge, `pending_o[k]` stays 1.
- R6: Driving `enable_i[k]` to 0 clears `pending_o[k]` at the next clock edge.
- R7: `irq_o` is 1 exactly when some channel has both `pending_o[k]` and `mask_i[k]` at 1. The mask does not affect `pending_o`.
- R8: `rx_ready_o` is the OR of the receive-normal flag bits and `tx_ready_o` is the OR of the transmit-normal flag bits. Both follow the flags combinationally, whatever the enable state.
- R9: While reset is active, `pending_o` is 0 and `irq_o` is 0. A flag already high when reset is released does not produce a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flag_i | input | NUM_CH*FLAGS_PER_CH | Status flag levels, grouped per channel |
| enable_i | input | NUM_CH | Per-channel enable |
| mask_i | input | NUM_CH | Per-channel mask toward `irq_o` |
| ack_i | input | NUM_CH | Per-channel acknowledge/clear strobe |
| pending_o | output | NUM_CH | Latched request per channel |
| irq_o | output | 1 | Combined masked interrupt request |
| rx_ready_o | output | 1 | Level of the receive-normal flag group |
| tx_ready_o | output | 1 | Level of the transmit-normal flag group |

## Verification
Pending bits move one clock edge after the flag, enable or acknowledge values that cause them. `irq_o` follows `pending_o` and `mask_i` with no further delay. The ready outputs follow the flags with no clock at all. The bench drives every input on the falling edge and samples on the following falling edge, after exactly one rising edge. So each pending bit is read in the first cycle it may have changed, and the combinational outputs are read against the inputs still applied.

// File: rtl/serint_pkg.sv
package serint_pkg;

    localparam int NUM_CH      = 4;
    localparam int CH_RX_NORM  = 0;
    localparam int CH_RX_ERR   = 1;
    localparam int CH_TX_NORM  = 2;
    localparam int CH_TX_ERR   = 3;

    // Per-channel registered state: last sampled flag level and request latch.
    typedef struct packed {
        logic flag_q;
        logic pend_q;
    } cell_state_t;

endpackage

// File: rtl/serint_flag_or.sv
module serint_flag_or #(
    parameter int NUM_CH       = 4,
    parameter int FLAGS_PER_CH = 2,
    localparam int FLAG_W      = NUM_CH * FLAGS_PER_CH
) (
    input  logic [FLAG_W-1:0] flag_i,
    output logic [NUM_CH-1:0] level_o
);

    // One reduction per channel over its own slice of flag bits.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_or
        assign level_o[ch] = |flag_i[ch*FLAGS_PER_CH +: FLAGS_PER_CH];
    end

endmodule

// File: rtl/serint_edge_cell.sv
module serint_edge_cell
    import serint_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    input  logic enable_i,
    input  logic ack_i,
    output logic pend_o
);

    cell_state_t state_d, state_q;
    logic        rise;

    always_comb begin
        state_d        = state_q;
        rise           = level_i & ~state_q.flag_q;
        state_d.flag_q = level_i;
        if (!enable_i) begin
            state_d.pend_q = 1'b0;
        end else if (rise) begin
            state_d.pend_q = 1'b1;
        end else if (ack_i) begin
            state_d.pend_q = 1'b0;
        end
    end

    // The flag history resets high so that a flag already set at reset release is not an edge.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.flag_q <= 1'b1;
            state_q.pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pend_o = state_q.pend_q;

    assert_capture_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_i && !state_q.flag_q && enable_i) |=> pend_o);

    assert_no_stale_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pend_o) |-> ($past(enable_i) && $past(level_i)));

    assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_o && !ack_i && enable_i) |=> pend_o);

    assert_edge_beats_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && enable_i && level_i && !state_q.flag_q) |=> pend_o);

    assert_disable_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> !pend_o);

    assert_level_no_retrigger_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pend_o && $past(level_i) && level_i) |=> !pend_o);

endmodule

// File: rtl/serint_irq_merge.sv
module serint_irq_merge #(
    parameter int NUM_CH = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] pend_i,
    input  logic [NUM_CH-1:0] mask_i,
    output logic              irq_o
);

    logic [NUM_CH-1:0] gated;

    always_comb begin
        gated = pend_i & mask_i;
        irq_o = |gated;
    end

    assert_masked_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_i == '0) |-> !irq_o);

    assert_unmasked_fires_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_i[0] && mask_i[0]) |-> irq_o);

endmodule

// File: rtl/serial_irq_edge_ctrl.sv
module serial_irq_edge_ctrl
    import serint_pkg::*;
#(
    parameter int FLAGS_PER_CH = 2,
    localparam int FLAG_W      = NUM_CH * FLAGS_PER_CH
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [FLAG_W-1:0] flag_i,
    input  logic [NUM_CH-1:0] enable_i,
    input  logic [NUM_CH-1:0] mask_i,
    input  logic [NUM_CH-1:0] ack_i,
    output logic [NUM_CH-1:0] pending_o,
    output logic              irq_o,
    output logic              rx_ready_o,
    output logic              tx_ready_o
);

    logic [NUM_CH-1:0] level;

    serint_flag_or #(
        .NUM_CH       (NUM_CH),
        .FLAGS_PER_CH (FLAGS_PER_CH)
    ) u_flag_or (
        .flag_i  (flag_i),
        .level_o (level)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cell
        serint_edge_cell u_cell (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .level_i  (level[ch]),
            .enable_i (enable_i[ch]),
            .ack_i    (ack_i[ch]),
            .pend_o   (pending_o[ch])
        );
    end

    serint_irq_merge #(
        .NUM_CH (NUM_CH)
    ) u_merge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pend_i (pending_o),
        .mask_i (mask_i),
        .irq_o  (irq_o)
    );

    // Level outputs for a data mover; independent of the interrupt enables.
    assign rx_ready_o = level[CH_RX_NORM];
    assign tx_ready_o = level[CH_TX_NORM];

    assert_reset_quiet_R9: assert property (@(posedge clk_i)
        !rst_ni |-> (pending_o == '0 && !irq_o));

endmodule

// File: tb/serial_irq_edge_ctrl_tb.sv
module serial_irq_edge_ctrl_tb;

    localparam int NCH = 4;
    localparam int FPC = 2;
    localparam int NV  = 15;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH*FPC-1:0] flags = '0;
    logic [NCH-1:0]   en = '0;
    logic [NCH-1:0]   mask = '0;
    logic [NCH-1:0]   ack = '0;
    logic [NCH-1:0]   pend;
    logic             irq;
    logic             rx_rdy;
    logic             tx_rdy;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    serial_irq_edge_ctrl #(.FLAGS_PER_CH(FPC)) u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .flag_i     (flags),
        .enable_i   (en),
        .mask_i     (mask),
        .ack_i      (ack),
        .pending_o  (pend),
        .irq_o      (irq),
        .rx_ready_o (rx_rdy),
        .tx_ready_o (tx_rdy)
    );

    // {flags, enable, mask, ack, expected pending, expected irq, expected {tx_rdy, rx_rdy}}
    localparam logic [26:0] VEC [NV] = '{
        {8'h00, 4'hF, 4'hF, 4'h0, 4'b0000, 1'b0, 2'b00}, // R1 idle
        {8'h01, 4'hF, 4'hF, 4'h0, 4'b0001, 1'b1, 2'b01}, // R1 rx-normal rise
        {8'h01, 4'hF, 4'hF, 4'h0, 4'b0001, 1'b1, 2'b01}, // R2 level held
        {8'h01, 4'hF, 4'hF, 4'h1, 4'b0000, 1'b0, 2'b01}, // R4 ack, R2 no retrigger
        {8'h00, 4'hF, 4'hF, 4'h0, 4'b0000, 1'b0, 2'b00}, // R1 fall
        {8'h02, 4'hF, 4'hF, 4'h0, 4'b0001, 1'b1, 2'b01}, // R1 second flag of group
        {8'h06, 4'hF, 4'hC, 4'h0, 4'b0011, 1'b0, 2'b01}, // R7 both masked
        {8'h06, 4'hF, 4'hE, 4'h0, 4'b0011, 1'b1, 2'b01}, // R7 rx-error unmasked
        {8'h04, 4'hF, 4'hE, 4'h1, 4'b0010, 1'b1, 2'b00}, // R4 ack ch0
        {8'h05, 4'hF, 4'hE, 4'h1, 4'b0011, 1'b1, 2'b01}, // R5 edge beats ack
        {8'h15, 4'hB, 4'hF, 4'h0, 4'b0011, 1'b1, 2'b11}, // R3 tx-normal rise while disabled
        {8'h15, 4'hF, 4'hF, 4'h0, 4'b0011, 1'b1, 2'b11}, // R3 enabled later: nothing
        {8'h15, 4'h0, 4'hF, 4'h0, 4'b0000, 1'b0, 2'b11}, // R6 disable clears
        {8'h95, 4'h8, 4'hF, 4'h0, 4'b1000, 1'b1, 2'b11}, // R1 tx-error rise
        {8'h95, 4'h8, 4'hF, 4'h8, 4'b0000, 1'b0, 2'b11}  // R4 ack tx-error
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        #(20 * 4000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R9: flags high and channels enabled while reset is held.
        flags = 8'hFF;
        en    = 4'hF;
        mask  = 4'hF;
        repeat (3) @(negedge clk);
        check("R9 reset pending", 32'(pend), 32'h0);
        check("R9 reset irq", 32'(irq), 32'h0);
        check("R8 ready levels", 32'({tx_rdy, rx_rdy}), 32'h3);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 no request from flag high at release", 32'(pend), 32'h0);
        flags = 8'h00;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            flags = VEC[i][26:19];
            en    = VEC[i][18:15];
            mask  = VEC[i][14:11];
            ack   = VEC[i][10:7];
            @(negedge clk);
            check($sformatf("vec %0d pending (R1-group)", i), 32'(pend), 32'(VEC[i][6:3]));
            check($sformatf("vec %0d R7 irq", i), 32'(irq), 32'(VEC[i][2]));
            check($sformatf("vec %0d R8 ready", i), 32'({tx_rdy, rx_rdy}), 32'(VEC[i][1:0]));
        end

        // R8: ready levels ignore enables entirely.
        ack   = 4'h0;
        en    = 4'h0;
        flags = 8'h10;
        #1;
        check("R8 tx ready while disabled", 32'({tx_rdy, rx_rdy}), 32'h2);

        // R6/R3: re-enable with level high gives nothing; a fresh rise does.
        @(negedge clk);
        en = 4'h4;
        @(negedge clk);
        check("R3 stale level after enable", 32'(pend), 32'h0);
        flags = 8'h00;
        @(negedge clk);
        flags = 8'h20;
        @(negedge clk);
        check("R1 fresh rise tx-normal", 32'(pend), 32'h4);
        check("R7 irq from tx-normal", 32'(irq), 32'h1);

        // R9: asynchronous reset clears a pending request.
        rst_n = 1'b0;
        #1;
        check("R9 reset clears pending", 32'(pend), 32'h0);
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule